// File: doc/BRIEF.md
# Multiplexed Card-Controller Bus Bridge

This block sits between a simple processor request port and an external card-controller bus that carries both address and data over one 16-bit lane. The processor address space holds two windows, one per external controller, each with its own active-low chip select and its own enable input. Each window is cut into four equal regions, and the region an address falls in picks the card access space: attribute memory, I/O, common memory or the controller's own registers.

A request to an enabled window becomes a short, fixed bus sequence. The first bus cycle carries a header word that packs the top of the card address, the access space, the transfer size and the slot number. The second carries the low half of the card address. Then come one data cycle, or two for a 32-bit access. The chip select then rises and a single-cycle response returns, with read data for a read. A request to a disabled window, to an address outside both windows, or with an unsupported size is answered at once with an error response and never reaches the bus.

Top module: `pcb_bridge`

## Requirements
- R1: After reset `card_cs_n` is all ones, `card_bus_oe` and `resp_valid` are 0, `card_bus_dir` is 1 and `req_ready` is 1.
- R2: Address bits [31:28] equal to 4 select window 0 (`card_cs_n[0]` low, slot bit 0). A value of 5 selects window 1 (`card_cs_n[1]` low, slot bit 1). At most one chip select is ever low.
- R3: In the first cycle after acceptance, `card_bus_out` is {addr[25:16], addr[27:26], size code, slot}. The space code is addr[27:26]: 0 attribute, 1 I/O, 2 common memory, 3 registers. `req_size` 0/1/2 means byte/halfword/word, and the size codes are 3'b001, 3'b010 and 3'b100.
- R4: In the second cycle after acceptance, `card_bus_out` is addr[15:0].
- R5: A write drives data in the cycles after the address cycle. A byte write drives {8'h00, wdata[7:0]} and a halfword write drives wdata[15:0]. A word write drives wdata[15:0] and then wdata[31:16].
- R6: In every read data cycle `card_bus_oe` and `card_bus_dir` are 0 and `card_bus_in` is sampled at the end of the cycle. The read result is the zero-extended low byte for a byte read, the 16-bit value for a halfword read, and {second beat, first beat} for a word read.
- R7: In the cycle after the last data cycle, all chip selects are high and `card_bus_oe` is 0. `resp_valid` is 1 for exactly that one cycle, with `resp_err` 0.
- R8: A request is answered with `resp_valid` and `resp_err` set, `resp_rdata` zero, in the cycle after acceptance, with no chip select low and `card_bus_oe` 0, when any of these holds:
  - its window's `win_enable` bit is 0;
  - address bits [31:28] are neither 4 nor 5;
  - `req_size` is 3.
- R9: `req_ready` is 1 only while idle. A request held during a transaction, including its response cycle, is accepted only in the cycle after the response.
- R10: `card_bus_oe` is 1 only in header, address and write-data cycles, and only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_enable | input | 2 | Per-window enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request accepted this cycle if valid |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion |
| resp_err | output | 1 | Completion is an error |
| resp_rdata | output | 32 | Read result |
| card_cs_n | output | 2 | Active-low chip selects, one per window |
| card_bus_out | output | 16 | Value driven onto the shared lane |
| card_bus_oe | output | 1 | Lane drive enable |
| card_bus_dir | output | 1 | Transceiver direction, 1 outbound |
| card_bus_in | input | 16 | Value read from the shared lane |

## Verification
Two events can land in the same cycle: a response completing and the next request arriving. The bench holds `req_valid` high with a second request through the whole first transaction. It then checks four things: `req_ready` stays low through the response cycle, the chip selects are high there, acceptance happens in the following idle cycle, and the second header appears one cycle after that. The same overlap is provoked with an error completion followed at once by a valid request. In that case the error cycle must not touch the bus and must not swallow the new request.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_ADR,
      ST_DAT,
      ST_FIN,
      ST_ERR
   } pcb_state_t;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   function automatic logic [2:0] size_code(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_code = 3'b001;
         SZ_HALF: size_code = 3'b010;
         default: size_code = 3'b100;
      endcase
   endfunction

endpackage

// File: rtl/pcb_decode.sv
module pcb_decode #(
   parameter int                   ADDR_W   = 32,
   parameter int                   NUM_WIN  = 2,
   parameter int                   TAG_W    = 4,
   parameter logic [NUM_WIN*TAG_W-1:0] WIN_TAGS = {4'h5, 4'h4},
   localparam int                  IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [1:0]         size,
   input  logic [NUM_WIN-1:0] win_enable,
   output logic               ok,
   output logic [IDX_W-1:0]   win_idx
);
   import pcb_pkg::*;

   logic [NUM_WIN-1:0] match;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      assign match[w] = (addr[ADDR_W-1 -: TAG_W] == WIN_TAGS[w*TAG_W +: TAG_W]);
   end

   always_comb begin
      win_idx = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (match[w]) win_idx = IDX_W'(w);
      end
   end

   assign ok = (|(match & win_enable)) && (size != 2'd3);

endmodule

// File: rtl/pcb_seq.sv
module pcb_seq #(
   parameter int  BEATS  = 2,
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              ok,
   input  logic [1:0]        size,
   output pcb_pkg::pcb_state_t state,
   output logic [BEAT_W-1:0] beat,
   output logic              accept
);
   import pcb_pkg::*;

   logic [BEAT_W-1:0] last_q;

   assign accept = (state == ST_IDLE) && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         beat   <= '0;
         last_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state  <= ok ? ST_HDR : ST_ERR;
                  last_q <= (size == SZ_WORD) ? BEAT_W'(BEATS - 1) : '0;
                  beat   <= '0;
               end
            end
            ST_HDR: state <= ST_ADR;
            ST_ADR: begin
               state <= ST_DAT;
               beat  <= '0;
            end
            ST_DAT: begin
               if (beat == last_q) state <= ST_FIN;
               else                beat  <= beat + 1'b1;
            end
            ST_FIN:  state <= ST_IDLE;
            ST_ERR:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pcb_dpath.sv
module pcb_dpath #(
   parameter int  ADDR_W  = 32,
   parameter int  DATA_W  = 32,
   parameter int  BUS_W   = 16,
   parameter int  IDX_W   = 1,
   localparam int BEATS   = DATA_W / BUS_W,
   localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int CARD_AW = ADDR_W - 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic                ok,
   input  pcb_pkg::pcb_state_t state,
   input  logic [BEAT_W-1:0]   beat,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [IDX_W-1:0]    win_idx,
   input  logic [BUS_W-1:0]    card_bus_in,
   output logic [BUS_W-1:0]    bus_out,
   output logic                write_q,
   output logic [IDX_W-1:0]    slot_q,
   output logic [DATA_W-1:0]   rdata
);
   import pcb_pkg::*;

   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;
   logic [DATA_W-1:0] wdata_q;
   logic [BUS_W-1:0]  wbeat  [BEATS];
   logic [BUS_W-1:0]  rbeat  [BEATS];
   logic [BUS_W-1:0]  hdr_w;
   logic [BUS_W-1:0]  wr_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         size_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         slot_q  <= '0;
      end else if (accept && ok) begin
         addr_q  <= req_addr;
         size_q  <= req_size;
         wdata_q <= req_wdata;
         write_q <= req_write;
         slot_q  <= win_idx;
      end
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_beat
      assign wbeat[b] = wdata_q[b*BUS_W +: BUS_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbeat[b] <= '0;
         else if (accept)
            rbeat[b] <= '0;
         else if (state == ST_DAT && !write_q && beat == BEAT_W'(b))
            rbeat[b] <= card_bus_in;
      end
   end

   assign hdr_w = {addr_q[CARD_AW-1 -: 10], addr_q[CARD_AW+1 -: 2],
                   size_code(size_q), slot_q[0]};

   always_comb begin
      wr_w = wbeat[beat];
      if (size_q == SZ_BYTE) wr_w = {{(BUS_W-8){1'b0}}, wbeat[0][7:0]};
   end

   always_comb begin
      case (state)
         ST_HDR:  bus_out = hdr_w;
         ST_ADR:  bus_out = addr_q[BUS_W-1:0];
         ST_DAT:  bus_out = write_q ? wr_w : '0;
         default: bus_out = '0;
      endcase
   end

   always_comb begin
      rdata = '0;
      case (size_q)
         SZ_BYTE: rdata[7:0] = rbeat[0][7:0];
         SZ_HALF: rdata[BUS_W-1:0] = rbeat[0];
         default: begin
            for (int b = 0; b < BEATS; b++) rdata[b*BUS_W +: BUS_W] = rbeat[b];
         end
      endcase
   end

endmodule

// File: rtl/pcb_bridge.sv
module pcb_bridge #(
   parameter int                       ADDR_W   = 32,
   parameter int                       DATA_W   = 32,
   parameter int                       BUS_W    = 16,
   parameter int                       NUM_WIN  = 2,
   parameter int                       TAG_W    = 4,
   parameter logic [NUM_WIN*TAG_W-1:0] WIN_TAGS = {4'h5, 4'h4}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_WIN-1:0] win_enable,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               resp_valid,
   output logic               resp_err,
   output logic [DATA_W-1:0]  resp_rdata,
   output logic [NUM_WIN-1:0] card_cs_n,
   output logic [BUS_W-1:0]   card_bus_out,
   output logic               card_bus_oe,
   output logic               card_bus_dir,
   input  logic [BUS_W-1:0]   card_bus_in
);
   import pcb_pkg::*;

   localparam int BEATS  = DATA_W / BUS_W;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   if (BUS_W != 16) begin : g_bad_bus
      $error("pcb_bridge: header layout needs a 16-bit lane");
   end
   if (ADDR_W != 32 || TAG_W != 4) begin : g_bad_addr
      $error("pcb_bridge: window layout needs 32-bit addresses and 4-bit tags");
   end
   if (DATA_W != BEATS * BUS_W || BEATS < 1) begin : g_bad_data
      $error("pcb_bridge: data width must be a multiple of the lane width");
   end

   pcb_state_t        state;
   logic [BEAT_W-1:0] beat;
   logic              accept;
   logic              ok;
   logic [IDX_W-1:0]  win_idx;
   logic              write_q;
   logic [IDX_W-1:0]  slot_q;
   logic [DATA_W-1:0] rdata;
   logic              active;

   pcb_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_WIN (NUM_WIN),
      .TAG_W   (TAG_W),
      .WIN_TAGS(WIN_TAGS)
   ) u_decode (
      .addr      (req_addr),
      .size      (req_size),
      .win_enable(win_enable),
      .ok        (ok),
      .win_idx   (win_idx)
   );

   pcb_seq #(.BEATS(BEATS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .ok       (ok),
      .size     (req_size),
      .state    (state),
      .beat     (beat),
      .accept   (accept)
   );

   pcb_dpath #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .BUS_W (BUS_W),
      .IDX_W (IDX_W)
   ) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .ok         (ok),
      .state      (state),
      .beat       (beat),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_wdata  (req_wdata),
      .win_idx    (win_idx),
      .card_bus_in(card_bus_in),
      .bus_out    (card_bus_out),
      .write_q    (write_q),
      .slot_q     (slot_q),
      .rdata      (rdata)
   );

   assign active = (state == ST_HDR) || (state == ST_ADR) || (state == ST_DAT);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cs
      assign card_cs_n[w] = !(active && slot_q == IDX_W'(w));
   end

   assign req_ready    = (state == ST_IDLE);
   assign resp_valid   = (state == ST_FIN) || (state == ST_ERR);
   assign resp_err     = (state == ST_ERR);
   assign resp_rdata   = (state == ST_FIN) ? rdata : '0;
   assign card_bus_oe  = (state == ST_HDR) || (state == ST_ADR) ||
                         (state == ST_DAT && write_q);
   assign card_bus_dir = !(state == ST_DAT && !write_q);

endmodule

// File: rtl/pcb_bridge_chk.sv
module pcb_bridge_chk #(
   parameter int NUM_WIN = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               resp_valid,
   input logic               resp_err,
   input logic [NUM_WIN-1:0] card_cs_n,
   input logic               card_bus_oe,
   input logic               card_bus_dir
);

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~card_cs_n) <= 1); // R2

   AST_ACCEPT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!(&card_cs_n) || (resp_valid && resp_err))); // R3

   AST_READ_TURNED: assert property (@(posedge clk) disable iff (!rst_n)
      !card_bus_dir |-> (!card_bus_oe && !(&card_cs_n))); // R6

   AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R7

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_err) |-> ((&card_cs_n) && !card_bus_oe)); // R8

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ((&card_cs_n) && !resp_valid)); // R9

   AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      card_bus_oe |-> !(&card_cs_n)); // R10

endmodule

bind pcb_bridge pcb_bridge_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .resp_valid  (resp_valid),
   .resp_err    (resp_err),
   .card_cs_n   (card_cs_n),
   .card_bus_oe (card_bus_oe),
   .card_bus_dir(card_bus_dir)
);

// File: tb/pcb_bridge_bench.sv
module pcb_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  win_enable = 2'b11;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        resp_valid;
   logic        resp_err;
   logic [31:0] resp_rdata;
   logic [1:0]  card_cs_n;
   logic [15:0] card_bus_out;
   logic        card_bus_oe;
   logic        card_bus_dir;
   logic [15:0] card_bus_in = '0;

   int vectors = 0;
   int fails   = 0;

   always #2.5 clk = ~clk;

   pcb_bridge u_pcb_bridge (
      .clk(clk), .rst_n(rst_n), .win_enable(win_enable),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .card_cs_n(card_cs_n), .card_bus_out(card_bus_out),
      .card_bus_oe(card_bus_oe), .card_bus_dir(card_bus_dir),
      .card_bus_in(card_bus_in)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] hdr(input logic [31:0] a, input logic [1:0] sz);
      logic [2:0] code;
      code = (sz == 2'd0) ? 3'b001 : (sz == 2'd1) ? 3'b010 : 3'b100;
      return {a[25:16], a[27:26], code, a[28]};
   endfunction

   // Drives one request and checks every bus cycle and the response.
   task automatic xfer(input string name, input logic [31:0] a, input logic wr,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input logic [15:0] rd0, input logic [15:0] rd1);
      logic [1:0]  cs_exp;
      logic [31:0] rexp;
      int          nb;
      cs_exp = a[28] ? 2'b01 : 2'b10;
      nb     = (sz == 2'd2) ? 2 : 1;
      @(negedge clk);
      chk({name, " R9 ready before"}, 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk({name, " R2 cs in header"}, 32'(card_cs_n), 32'(cs_exp));
      chk({name, " R3 header"}, 32'(card_bus_out), 32'(hdr(a, sz)));
      chk({name, " R10 oe header"}, 32'(card_bus_oe), 32'd1);
      chk({name, " R9 ready busy"}, 32'(req_ready), 32'd0);
      @(negedge clk);
      chk({name, " R4 address"}, 32'(card_bus_out), 32'(a[15:0]));
      chk({name, " R10 oe address"}, 32'(card_bus_oe), 32'd1);
      for (int b = 0; b < nb; b++) begin
         @(negedge clk);
         chk({name, " R2 cs in data"}, 32'(card_cs_n), 32'(cs_exp));
         if (wr) begin
            chk({name, " R5 write data"}, 32'(card_bus_out),
                (sz == 2'd0) ? {24'h0, wd[7:0]} : (b == 0) ? {16'h0, wd[15:0]} : {16'h0, wd[31:16]});
            chk({name, " R10 oe write"}, 32'(card_bus_oe), 32'd1);
         end else begin
            card_bus_in = (b == 0) ? rd0 : rd1;
            chk({name, " R6 oe/dir read"}, {30'h0, card_bus_oe, card_bus_dir}, 32'd0);
         end
      end
      @(negedge clk);
      card_bus_in = 16'hdead;
      rexp = wr ? 32'h0 : (sz == 2'd0) ? {24'h0, rd0[7:0]} : (sz == 2'd1) ? {16'h0, rd0} : {rd1, rd0};
      chk({name, " R7 resp valid/err"}, {30'h0, resp_valid, resp_err}, 32'd2);
      chk({name, " R7 cs released"}, 32'(card_cs_n), 32'd3);
      chk({name, " R7 oe off"}, 32'(card_bus_oe), 32'd0);
      if (!wr) chk({name, " R6 read data"}, resp_rdata, rexp);
      @(negedge clk);
      chk({name, " R7 resp single"}, 32'(resp_valid), 32'd0);
      chk({name, " R9 ready after"}, 32'(req_ready), 32'd1);
   endtask

   // A rejected request: error in the next cycle, no bus activity.
   task automatic reject(input string name, input logic [31:0] a, input logic [1:0] sz);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = 1'b1; req_size = sz; req_wdata = 32'hffff_ffff;
      @(negedge clk);
      req_valid = 1'b0;
      chk({name, " R8 err resp"}, {30'h0, resp_valid, resp_err}, 32'd3);
      chk({name, " R8 no cs"}, 32'(card_cs_n), 32'd3);
      chk({name, " R8 no drive"}, 32'(card_bus_oe), 32'd0);
      chk({name, " R8 rdata zero"}, resp_rdata, 32'd0);
      @(negedge clk);
      chk({name, " R8 idle after"}, {29'h0, req_ready, card_cs_n}, 32'h7);
   endtask

   // Request held through the first transaction's response cycle.
   task automatic overlap();
      logic [31:0] a2;
      a2 = 32'h5800_1234;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h4400_0010; req_write = 1'b1; req_size = 2'd1;
      req_wdata = 32'h0000_abcd;
      @(negedge clk);
      req_addr = a2; req_write = 1'b0; req_size = 2'd1;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk("ovl R9 ready in response", {30'h0, req_ready, resp_valid}, 32'd1);
      chk("ovl R7 cs in response", 32'(card_cs_n), 32'd3);
      @(negedge clk);
      chk("ovl R9 accepted in idle", {29'h0, req_ready, card_cs_n}, 32'h7);
      @(negedge clk);
      req_valid = 1'b0;
      chk("ovl R3 second header", 32'(card_bus_out), 32'(hdr(a2, 2'd1)));
      chk("ovl R2 second window", 32'(card_cs_n), 32'd1);
      @(negedge clk);
      @(negedge clk);
      card_bus_in = 16'h7e57;
      @(negedge clk);
      chk("ovl R6 second read", resp_rdata, 32'h0000_7e57);
      @(negedge clk);
      // Error completion directly followed by a valid request.
      req_valid = 1'b1; req_addr = 32'h6000_0000; req_size = 2'd0;
      @(negedge clk);
      req_addr = 32'h4c00_0002; req_write = 1'b0; req_size = 2'd0;
      chk("ovl R8 error quiet", {29'h0, resp_err, card_cs_n}, 32'h7);
      chk("ovl R9 no accept on error", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("ovl R9 idle after error", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("ovl R3 header after error", 32'(card_bus_out), 32'(hdr(32'h4c00_0002, 2'd0)));
      @(negedge clk);
      @(negedge clk);
      card_bus_in = 16'h12c3;
      @(negedge clk);
      chk("ovl R6 byte read", resp_rdata, 32'h0000_00c3);
      @(negedge clk);
   endtask

   initial begin
      #1;
      chk("R1 cs reset", 32'(card_cs_n), 32'd3);
      chk("R1 oe/resp reset", {30'h0, card_bus_oe, resp_valid}, 32'd0);
      chk("R1 ready/dir reset", {30'h0, req_ready, card_bus_dir}, 32'd3);
      #20 rst_n = 1'b1;
      xfer("attr byte wr", 32'h4012_3456, 1'b1, 2'd0, 32'h0000_00a5, 16'h0, 16'h0);
      xfer("io half wr",   32'h45a5_8001, 1'b1, 2'd1, 32'h1357_9bdf, 16'h0, 16'h0);
      xfer("mem word wr",  32'h5bff_fffe, 1'b1, 2'd2, 32'hcafe_f00d, 16'h0, 16'h0);
      xfer("reg word rd",  32'h5c00_0040, 1'b0, 2'd2, 32'h0, 16'h1111, 16'h2222);
      xfer("mem byte rd",  32'h4800_0003, 1'b0, 2'd0, 32'h0, 16'hbeef, 16'h0);
      xfer("attr half rd", 32'h5000_0002, 1'b0, 2'd1, 32'h0, 16'h8421, 16'h0);
      win_enable = 2'b10;
      reject("win0 disabled", 32'h4000_0000, 2'd1);
      xfer("win1 still on", 32'h5400_0100, 1'b1, 2'd1, 32'h0000_5a5a, 16'h0, 16'h0);
      win_enable = 2'b01;
      reject("win1 disabled", 32'h5000_0000, 2'd1);
      win_enable = 2'b11;
      reject("outside", 32'h3fff_fffc, 2'd2);
      reject("bad size", 32'h4000_0000, 2'd3);
      overlap();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule